// File: doc/BRIEF.md
# Selectable Video Output Formatter

This block sits at the end of a camera pixel pipeline. It takes one processed pixel at a time and turns it into a stream on an 8-bit output bus. A pixel carries luminance plus both chroma values, or a 5:6:5 RGB triple, or a 10-bit raw sensor sample. Each accepted pixel becomes exactly two bytes on consecutive clocks. The horizontal and vertical sync inputs are passed out alongside the data with a one-clock delay, and each can be inverted on its own. The block does no colour arithmetic and generates no timing of its own. It only orders and packs bytes, inserts line timing codes in the embedded-sync mode, and applies sync polarity.

Upstream presents a pixel with `pix_valid_i` while `hsync_i` is low, which marks the active part of a line. Pixels arrive at most every second clock, because each pixel occupies the bus for two clocks. The output format settings are captured at the start of each line and held until the line ends. The sync polarity bits take effect on the next clock.

The sequencer has five states:
- **IDLE**: horizontal blanking.
- **SAV**: the rest of the start-of-line code.
- **ACT_A**: waiting for a pixel, or emitting its first byte.
- **ACT_B**: emitting the second byte.
- **EAV**: the rest of the end-of-line code.

Transitions:
- IDLE→SAV when `hsync_i` falls in the embedded-sync mode.
- IDLE→ACT_A when `hsync_i` falls in any other mode.
- SAV→ACT_A after the fourth code byte.
- ACT_A→ACT_B on an accepted pixel.
- ACT_B→ACT_A always.
- ACT_A→EAV when `hsync_i` rises in the embedded-sync mode.
- ACT_A→IDLE when `hsync_i` rises in any other mode.
- EAV→IDLE after the fourth code byte.

Top module: `vid_byte_formatter`

## Requirements
- R1: While `rst_n` is low, `dout_o`, `hsync_o` and `vsync_o` are all 0.
- R2: `mode_i` selects the packing: 0 = 4:2:2 with embedded timing codes, 1 = 4:2:2 with separate syncs only, 2 = RGB 5:6:5, 3 = raw 10-bit. Each accepted pixel yields two bytes on the two clocks after it is sampled.
- R3: In both 4:2:2 modes, `c_first_i`=0 sends luminance then chroma per pixel, and 1 sends chroma then luminance. The chroma byte of an even pixel in the line is Cb if `cr_first_i`=0 and Cr if it is 1. An odd pixel sends the other chroma component.
- R4: The even/odd pixel parity restarts at the first pixel of every line.
- R5: In RGB mode with `rgb_swap_i`=0, the first byte is {R[4:0],G[5:3]} and the second is {G[2:0],B[4:0]}.
- R6: In RGB mode with `rgb_swap_i`=1, the first byte is {B[4:0],G[5:3]} and the second is {G[2:0],R[4:0]}.
- R7: In raw mode the first byte is {6'b000000,D[9:8]} and the second is D[7:0].
- R8: In the embedded mode, the clock after `hsync_i` falls outputs FF, 00, 00, XY. XY is {1,F,V,H,V^H,F^H,F^V,F^V^H}, with H=0, F=`field_i` and V=`vsync_i` sampled at the fall.
- R9: In the embedded mode, `hsync_i` rising in ACT_A outputs FF, 00, 00, XY with H=1 and F and V sampled at the rise. It then returns to IDLE.
- R10: In the embedded mode, pixel bytes 00 become 01 and FF become FE. In the separate-sync mode, pixel bytes pass unclipped.
- R11: `hsync_o` equals `hsync_i` XOR `hs_inv_i` and `vsync_o` equals `vsync_i` XOR `vs_inv_i`, as sampled at the previous clock edge.
- R12: The `mode_i`, `c_first_i`, `cr_first_i` and `rgb_swap_i` inputs are captured when a line starts. Changes made during a line do not affect that line.
- R13: When no byte is due, the bus carries `FILL_656` if the captured mode is 0 and `FILL_OTHER` otherwise. `pix_valid_i` is ignored in ACT_B, during timing codes and while `hsync_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_valid_i | input | 1 | Pixel strobe |
| hsync_i | input | 1 | Internal horizontal blanking, high outside active video |
| vsync_i | input | 1 | Internal vertical blanking |
| field_i | input | 1 | Field identifier |
| y_i | input | 8 | Luminance |
| cb_i | input | 8 | Blue-difference chroma |
| cr_i | input | 8 | Red-difference chroma |
| r_i | input | 5 | Red |
| g_i | input | 6 | Green |
| b_i | input | 5 | Blue |
| raw_i | input | 10 | Raw sensor sample |
| mode_i | input | 2 | Output format select |
| c_first_i | input | 1 | Chroma byte precedes luminance |
| cr_first_i | input | 1 | Even pixel carries Cr |
| rgb_swap_i | input | 1 | Blue in the first RGB byte |
| hs_inv_i | input | 1 | Invert horizontal sync output |
| vs_inv_i | input | 1 | Invert vertical sync output |
| dout_o | output | 8 | Output byte bus |
| hsync_o | output | 1 | Horizontal sync output |
| vsync_o | output | 1 | Vertical sync output |

## Verification
The bench keeps `FILL_656` at 0x80 and overrides `FILL_OTHER` to 0x5A. Idle bytes in the RGB, raw and separate-sync modes then differ from packed data, and a wrong fill choice or a byte emitted one clock early becomes visible. Lines of odd length test the per-line parity restart, and pixels whose components are 00 or FF separate clipping from pass-through. Format inputs changed in mid-line check that the configuration is held to line boundaries.

// File: rtl/vof_pkg.sv
package vof_pkg;

    localparam int BYTE_W = 8;
    localparam int RAW_W  = 10;
    localparam int R_W    = 5;
    localparam int G_W    = 6;
    localparam int B_W    = 5;
    localparam int TRC_LEN = 4;

    typedef enum logic [1:0] {
        OM_656 = 2'd0,
        OM_601 = 2'd1,
        OM_RGB = 2'd2,
        OM_RAW = 2'd3
    } omode_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SAV,
        S_ACTA,
        S_ACTB,
        S_EAV
    } seq_st_t;

    typedef struct packed {
        omode_t mode;
        logic   c_first;
        logic   cr_first;
        logic   rgb_swap;
    } fmt_cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] y;
        logic [BYTE_W-1:0] cb;
        logic [BYTE_W-1:0] cr;
        logic [R_W-1:0]    r;
        logic [G_W-1:0]    g;
        logic [B_W-1:0]    b;
        logic [RAW_W-1:0]  raw;
    } pix_t;

    function automatic logic [BYTE_W-1:0] xy_code(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [BYTE_W-1:0] clip_code(input logic [BYTE_W-1:0] d);
        if (d == '0)
            return BYTE_W'(1);
        else if (d == '1)
            return {{(BYTE_W-1){1'b1}}, 1'b0};
        else
            return d;
    endfunction

endpackage

// File: rtl/vof_byte_pack.sv
module vof_byte_pack
    import vof_pkg::*;
(
    input  fmt_cfg_t          cfg_i,
    input  pix_t              pix_i,
    input  logic              ph_i,
    output logic [BYTE_W-1:0] first_o,
    output logic [BYTE_W-1:0] second_o
);

    localparam int G_HI = BYTE_W - R_W;
    localparam int G_LO = G_W - G_HI;

    logic [BYTE_W-1:0] chroma;

    always_comb begin
        chroma   = (ph_i ^ cfg_i.cr_first) ? pix_i.cr : pix_i.cb;
        first_o  = '0;
        second_o = '0;
        unique case (cfg_i.mode)
            OM_656, OM_601: begin
                first_o  = cfg_i.c_first ? chroma : pix_i.y;
                second_o = cfg_i.c_first ? pix_i.y : chroma;
                if (cfg_i.mode == OM_656) begin
                    first_o  = clip_code(first_o);
                    second_o = clip_code(second_o);
                end
            end
            OM_RGB: begin
                if (cfg_i.rgb_swap) begin
                    first_o  = {pix_i.b, pix_i.g[G_W-1 -: G_HI]};
                    second_o = {pix_i.g[G_LO-1:0], pix_i.r};
                end else begin
                    first_o  = {pix_i.r, pix_i.g[G_W-1 -: G_HI]};
                    second_o = {pix_i.g[G_LO-1:0], pix_i.b};
                end
            end
            OM_RAW: begin
                first_o  = {{(2*BYTE_W-RAW_W){1'b0}}, pix_i.raw[RAW_W-1:BYTE_W]};
                second_o = pix_i.raw[BYTE_W-1:0];
            end
        endcase
    end

endmodule

// File: rtl/vof_sync.sv
module vof_sync #(
    parameter int N_SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SYNC-1:0] sync_i,
    input  logic [N_SYNC-1:0] inv_i,
    output logic [N_SYNC-1:0] sync_o
);

    for (genvar k = 0; k < N_SYNC; k++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sync_o[k] <= 1'b0;
            else
                sync_o[k] <= sync_i[k] ^ inv_i[k];
        end
    end

endmodule

// File: rtl/vof_seq.sv
module vof_seq
    import vof_pkg::*;
#(
    parameter logic [BYTE_W-1:0] FILL_656   = 8'h80,
    parameter logic [BYTE_W-1:0] FILL_OTHER = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid_i,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic              field_i,
    input  fmt_cfg_t          cfg_i,
    input  logic [BYTE_W-1:0] first_b_i,
    input  logic [BYTE_W-1:0] second_b_i,
    output fmt_cfg_t          cfg_q_o,
    output logic              ph_o,
    output logic [BYTE_W-1:0] dout_o
);

    localparam int CNT_W = $clog2(TRC_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TRC_LEN - 1);

    seq_st_t           st_q, st_d;
    fmt_cfg_t          cfg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] hold_q;
    logic [1:0]        fv_q;
    logic              ph_q;
    logic              pix_byte_q;

    function automatic logic [BYTE_W-1:0] fill_of(input omode_t m);
        return (m == OM_656) ? FILL_656 : FILL_OTHER;
    endfunction

    assign cfg_q_o = cfg_q;
    assign ph_o    = ph_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (!hsync_i) st_d = (cfg_i.mode == OM_656) ? S_SAV : S_ACTA;
            S_SAV:  if (cnt_q == CNT_LAST) st_d = S_ACTA;
            S_ACTA: begin
                if (hsync_i)
                    st_d = (cfg_q.mode == OM_656) ? S_EAV : S_IDLE;
                else if (pix_valid_i)
                    st_d = S_ACTB;
            end
            S_ACTB: st_d = S_ACTA;
            S_EAV:  if (cnt_q == CNT_LAST) st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= S_IDLE;
        else
            st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_o     <= '0;
            hold_q     <= '0;
            cnt_q      <= '0;
            fv_q       <= '0;
            ph_q       <= 1'b0;
            cfg_q      <= '0;
            pix_byte_q <= 1'b0;
        end else begin
            pix_byte_q <= 1'b0;
            unique case (st_q)
                S_IDLE: begin
                    if (!hsync_i) begin
                        cfg_q  <= cfg_i;
                        ph_q   <= 1'b0;
                        cnt_q  <= CNT_W'(1);
                        fv_q   <= {field_i, vsync_i};
                        dout_o <= (cfg_i.mode == OM_656) ? '1 : fill_of(cfg_i.mode);
                    end else begin
                        dout_o <= fill_of(cfg_q.mode);
                    end
                end
                S_SAV, S_EAV: begin
                    cnt_q  <= cnt_q + CNT_W'(1);
                    dout_o <= (cnt_q == CNT_LAST) ? xy_code(fv_q[1], fv_q[0], st_q == S_EAV) : '0;
                end
                S_ACTA: begin
                    if (hsync_i) begin
                        cnt_q  <= CNT_W'(1);
                        fv_q   <= {field_i, vsync_i};
                        dout_o <= (cfg_q.mode == OM_656) ? '1 : fill_of(cfg_q.mode);
                    end else if (pix_valid_i) begin
                        dout_o     <= first_b_i;
                        hold_q     <= second_b_i;
                        ph_q       <= ~ph_q;
                        pix_byte_q <= 1'b1;
                    end else begin
                        dout_o <= fill_of(cfg_q.mode);
                    end
                end
                S_ACTB: begin
                    dout_o     <= hold_q;
                    pix_byte_q <= 1'b1;
                end
                default: dout_o <= fill_of(cfg_q.mode);
            endcase
        end
    end

    // R13: the second byte of a pixel is always followed by a return to the pixel wait state
    assert_second_byte_R13: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == S_ACTB |=> st_q == S_ACTA);

    // R10: pixel bytes never carry a reserved code in the embedded mode
    assert_no_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_byte_q && cfg_q.mode == OM_656) |-> (dout_o != '0 && dout_o != '1));

    // R8: a timing code is never in progress with its byte counter at zero
    assert_code_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_SAV || st_q == S_EAV) |-> cnt_q != '0);

    // R4: leaving blanking always starts with even parity
    assert_line_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == S_IDLE && st_q != S_IDLE) |-> ph_q == 1'b0);

    // R12: captured settings hold for the whole line
    assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_IDLE && $past(st_q) != S_IDLE) |-> $stable(cfg_q));

endmodule

// File: rtl/vid_byte_formatter.sv
module vid_byte_formatter
    import vof_pkg::*;
#(
    parameter logic [7:0] FILL_656   = 8'h80,
    parameter logic [7:0] FILL_OTHER = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pix_valid_i,
    input  logic       hsync_i,
    input  logic       vsync_i,
    input  logic       field_i,
    input  logic [7:0] y_i,
    input  logic [7:0] cb_i,
    input  logic [7:0] cr_i,
    input  logic [4:0] r_i,
    input  logic [5:0] g_i,
    input  logic [4:0] b_i,
    input  logic [9:0] raw_i,
    input  logic [1:0] mode_i,
    input  logic       c_first_i,
    input  logic       cr_first_i,
    input  logic       rgb_swap_i,
    input  logic       hs_inv_i,
    input  logic       vs_inv_i,
    output logic [7:0] dout_o,
    output logic       hsync_o,
    output logic       vsync_o
);

    fmt_cfg_t          cfg_live, cfg_line;
    pix_t              pix;
    logic              ph;
    logic [BYTE_W-1:0] first_b, second_b;
    logic [1:0]        sync_out;

    assign cfg_live = '{mode: omode_t'(mode_i), c_first: c_first_i,
                        cr_first: cr_first_i, rgb_swap: rgb_swap_i};
    assign pix = '{y: y_i, cb: cb_i, cr: cr_i, r: r_i, g: g_i, b: b_i, raw: raw_i};

    vof_byte_pack u_pack (
        .cfg_i    (cfg_line),
        .pix_i    (pix),
        .ph_i     (ph),
        .first_o  (first_b),
        .second_o (second_b)
    );

    vof_seq #(
        .FILL_656   (FILL_656),
        .FILL_OTHER (FILL_OTHER)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid_i (pix_valid_i),
        .hsync_i     (hsync_i),
        .vsync_i     (vsync_i),
        .field_i     (field_i),
        .cfg_i       (cfg_live),
        .first_b_i   (first_b),
        .second_b_i  (second_b),
        .cfg_q_o     (cfg_line),
        .ph_o        (ph),
        .dout_o      (dout_o)
    );

    vof_sync #(.N_SYNC(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i ({vsync_i, hsync_i}),
        .inv_i  ({vs_inv_i, hs_inv_i}),
        .sync_o (sync_out)
    );

    assign hsync_o = sync_out[0];
    assign vsync_o = sync_out[1];

endmodule

// File: tb/test_vid_byte_formatter.sv
module test_vid_byte_formatter;

    localparam logic [7:0] F656 = 8'h80;
    localparam logic [7:0] FOTH = 8'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_valid_i = 1'b0, hsync_i = 1'b1, vsync_i = 1'b0, field_i = 1'b0;
    logic [7:0] y_i = '0, cb_i = '0, cr_i = '0;
    logic [4:0] r_i = '0, b_i = '0;
    logic [5:0] g_i = '0;
    logic [9:0] raw_i = '0;
    logic [1:0] mode_i = '0;
    logic c_first_i = 1'b0, cr_first_i = 1'b0, rgb_swap_i = 1'b0;
    logic hs_inv_i = 1'b0, vs_inv_i = 1'b0;
    logic [7:0] dout_o;
    logic hsync_o, vsync_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [1:0] cur_mode = 2'd0;
    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    vid_byte_formatter #(.FILL_656(F656), .FILL_OTHER(FOTH)) i_vid_byte_formatter (.*);

    function automatic logic [7:0] pv_y(int i);
        return (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'(i * 29 + 5);
    endfunction
    function automatic logic [7:0] pv_cb(int i);
        return (i == 2) ? 8'h00 : 8'(i * 53 + 17);
    endfunction
    function automatic logic [7:0] pv_cr(int i);
        return (i == 3) ? 8'hFF : 8'(i * 71 + 40);
    endfunction

    function automatic logic [7:0] clip(logic [7:0] d);
        return (d == 8'h00) ? 8'h01 : (d == 8'hFF) ? 8'hFE : d;
    endfunction

    function automatic logic [7:0] fill(logic [1:0] m);
        return (m == 2'd0) ? F656 : FOTH;
    endfunction

    function automatic logic [7:0] xy(logic f, logic v, logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [15:0] exp_pair(logic [1:0] md, logic cf, logic crf, logic sw, logic ph, int i);
        logic [7:0] c, a, b;
        logic [4:0] rr, bb;
        logic [5:0] gg;
        logic [9:0] rw;
        rr = 5'(i * 7 + 3); gg = 6'(i * 11 + 1); bb = 5'(i * 13 + 9); rw = 10'(i * 97 + 300);
        c = (ph ^ crf) ? pv_cr(i) : pv_cb(i);
        case (md)
            2'd0, 2'd1: begin
                a = cf ? c : pv_y(i);
                b = cf ? pv_y(i) : c;
                if (md == 2'd0) begin a = clip(a); b = clip(b); end
            end
            2'd2: begin
                a = sw ? {bb, gg[5:3]} : {rr, gg[5:3]};
                b = sw ? {gg[2:0], rr} : {gg[2:0], bb};
            end
            default: begin
                a = {6'b0, rw[9:8]};
                b = rw[7:0];
            end
        endcase
        return {a, b};
    endfunction

    task automatic set_pix(int i);
        y_i = pv_y(i); cb_i = pv_cb(i); cr_i = pv_cr(i);
        r_i = 5'(i * 7 + 3); g_i = 6'(i * 11 + 1); b_i = 5'(i * 13 + 9); raw_i = 10'(i * 97 + 300);
    endtask

    // driver: called at a falling edge, drives one cycle and queues what the next rising edge must produce
    task automatic step(logic vld, logic hs, logic [7:0] exp_d, string tag);
        pix_valid_i = vld;
        hsync_i = hs;
        exp_q.push_back({exp_d, hs ^ hs_inv_i, vsync_i ^ vs_inv_i});
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic run_line(int npix, logic [1:0] md, logic cf, logic crf, logic sw,
                            logic vs, logic fld, bit mid_change);
        logic ph;
        logic [15:0] pr;
        string base, t;
        mode_i = md; c_first_i = cf; cr_first_i = crf; rgb_swap_i = sw;
        vsync_i = vs; field_i = fld;
        base = (md == 2'd2) ? (sw ? "R6" : "R5") : (md == 2'd3) ? "R7" : "R3";
        step(1'b0, 1'b0, (md == 2'd0) ? 8'hFF : fill(md), (md == 2'd0) ? "R8" : "R13");
        cur_mode = md;
        if (md == 2'd0) begin
            step(1'b1, 1'b0, 8'h00, "R8 R13");
            step(1'b0, 1'b0, 8'h00, "R8");
            step(1'b0, 1'b0, xy(fld, vs, 1'b0), "R8");
        end
        ph = 1'b0;
        for (int i = 0; i < npix; i++) begin
            set_pix(i);
            pr = exp_pair(md, cf, crf, sw, ph, i);
            t = {base, " R2", (i == 0) ? " R4" : "", (md <= 2'd1 && i < 4) ? " R10" : "",
                 (mid_change && i > 0) ? " R12" : ""};
            step(1'b1, 1'b0, pr[15:8], t);
            if (mid_change && i == 0) begin
                mode_i = md ^ 2'd1; c_first_i = ~cf; cr_first_i = ~crf; rgb_swap_i = ~sw;
            end
            step(1'b1, 1'b0, pr[7:0], {t, " R13"});
            if (i % 2 == 1) step(1'b0, 1'b0, fill(md), "R13");
            ph = ~ph;
        end
        step(1'b1, 1'b1, (md == 2'd0) ? 8'hFF : fill(md), (md == 2'd0) ? "R9" : "R13");
        if (md == 2'd0) begin
            step(1'b0, 1'b1, 8'h00, "R9");
            step(1'b1, 1'b1, 8'h00, "R9 R13");
            step(1'b0, 1'b1, xy(fld, vs, 1'b1), "R9");
        end
        step(1'b1, 1'b1, fill(md), "R13");
    endtask

    // monitor: pops one expected item per rising edge, compares a little after the edge
    always begin
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) begin
            logic [9:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (dout_o !== e[9:2]) begin
                fails++;
                $display("FAIL %s data: got %02h expected %02h", t, dout_o, e[9:2]);
            end
            checks++;
            if ({hsync_o, vsync_o} !== e[1:0]) begin
                fails++;
                $display("FAIL R11 sync: got %b%b expected %b%b", hsync_o, vsync_o, e[1], e[0]);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (dout_o !== 8'h00 || hsync_o !== 1'b0 || vsync_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: got %02h %b %b expected 00 0 0", dout_o, hsync_o, vsync_o);
        end
        rst_n = 1'b1;
        step(1'b0, 1'b1, F656, "R13");
        step(1'b1, 1'b1, F656, "R13");
        run_line(5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        run_line(4, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 0);
        hs_inv_i = 1'b1;
        run_line(5, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 0);
        vs_inv_i = 1'b1;
        run_line(4, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0);
        hs_inv_i = 1'b0;
        run_line(3, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        run_line(3, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1);
        vs_inv_i = 1'b0;
        run_line(4, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0);
        run_line(3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1);
        run_line(3, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1);
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule